// File: doc/BRIEF.md
# Six-Channel Shadowed PWM Generator

This block generates six independent pulse-width-modulated outputs from a single clock. Software programs each channel through a small memory-mapped register window using a plain write strobe and a read strobe. Every period is a count of input clock cycles. Each period opens with a first phase whose length acts as the duty value, and the rest of the period is the complementary level. A control bit chooses the level of the first phase. A second control bit chooses the level the pin holds while the channel produces no waveform.

Period, first-phase length, repeat count and mode are written into shadow registers. They reach the running counter only after software requests an update, and the copy waits for the end of the current period, so a period is never cut short. A channel runs either continuously or in one-shot mode. In one-shot mode it emits a programmed number of periods, then raises a done flag and, if enabled, the shared interrupt. A one-shot run may be held back until a chosen edge of an external event input, which is synchronised with two flops.

Top module: `shpwm_top`

## Requirements
- R1: Channel c (0..5) decodes addresses c*0x20 through c*0x20+0x1F. Offsets within a window: 0x00 control, 0x04 repeat, 0x08 period, 0x0C first-phase length, 0x10 status. Repeat, period and first-phase read back the last written (shadow) value. Addresses in windows 6 and 7 and undefined offsets read 0, and `rdata` is 0 whenever `rd_en` is low.
- R2: Control bit positions: 0 start, 1 soft reset, 2 update request, 3 interrupt enable, 4 one-shot, 5 continuous, 6 trigger on rising event, 7 trigger on falling event, 8 first-phase level, 9 idle level. Bits 1 and 2 act only on the write that sets them and always read back as 0. The other bits read back as written.
- R3: Writes to repeat, period, first-phase and the mode bits (4 to 7) do not change a running waveform until an update request. While the channel is running, the new values take effect at the next period boundary. While it is stopped, they are copied on the clock edge after the update write, and a start that is pending then launches on the following edge.
- R4: While running, the counter steps through 0..period-1. The output equals the first-phase level while the count is below the first-phase length, and the inverse of that level otherwise. A length of 0 never enters the first phase. A length equal to or greater than the period holds the first-phase level for the whole period.
- R5: Clearing start returns the output to the idle level by the second clock edge after the write. Setting start again with no update request begins a new period from count 0 on the next edge, using the unchanged active values.
- R6: While stopped, waiting for a trigger or finished, the output equals the idle level bit. A change of that bit shows on the edge that writes it.
- R7: In one-shot mode the channel emits exactly the repeat-count number of periods. It then holds the idle level and sets status bit 0. A repeat count of 0 sets status bit 0 without emitting a period.
- R8: With trigger bit 6 or 7 set in one-shot mode, the channel waits at the idle level until the matching edge of its synchronised event input, and ignores the other edge.
- R9: `irq` is high while any channel has status bit 0 set together with its interrupt enable bit. Writing 1 to status bit 0 clears the flag.
- R10: A soft reset clears the counter, the active period, first-phase, repeat and mode values, and status. The output is at the idle level on the edge of the write. The shadow registers keep their contents.
- R11: A mode with both the one-shot and continuous bits set behaves as continuous and never sets the done flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all counts are in its cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; `rdata` is valid in the same cycle |
| addr | input | 8 | Byte address: channel in bits 7:5, offset in bits 4:0 |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, 0 when `rd_en` is low |
| evt_in | input | 6 | Asynchronous event input, one per channel |
| pwm_out | output | 6 | Waveform output, one per channel |
| irq | output | 1 | Combined completion interrupt |

## Verification
The in-RTL properties assume that each bus cycle carries at most one write or one read. They also assume that the event inputs are level signals, each held for at least three clock cycles, so that no edge is lost in the synchroniser. The bench changes the bus and event inputs only on falling clock edges, keeps every strobe high for exactly one cycle, and holds each event level for many cycles. Duty checks that do not depend on phase count first-phase cycles over whole multiples of the period. They do not sample single cycles, so they stay independent of when an update meets a period boundary.

// File: rtl/shpwm_pkg.sv
package shpwm_pkg;

  localparam int CTRL_BITS      = 10;
  localparam int CTRL_RUN       = 0;
  localparam int CTRL_SRST      = 1;
  localparam int CTRL_UPD       = 2;
  localparam int CTRL_IE        = 3;
  localparam int CTRL_ONE       = 4;
  localparam int CTRL_CONT      = 5;
  localparam int CTRL_TRIG_R    = 6;
  localparam int CTRL_TRIG_F    = 7;
  localparam int CTRL_LVL_FIRST = 8;
  localparam int CTRL_LVL_IDLE  = 9;

  localparam logic [4:0] OFS_CTRL = 5'h00;
  localparam logic [4:0] OFS_REP  = 5'h04;
  localparam logic [4:0] OFS_PER  = 5'h08;
  localparam logic [4:0] OFS_FP   = 5'h0C;
  localparam logic [4:0] OFS_STAT = 5'h10;

  typedef enum logic [1:0] {CH_IDLE, CH_WAIT, CH_RUN, CH_DONE} ch_state_e;

  typedef struct packed {
    logic one;
    logic cont;
    logic trig_r;
    logic trig_f;
  } mode_t;

  // continuous wins when both mode bits are set
  function automatic mode_t decode_mode(input logic [CTRL_BITS-1:0] c);
    mode_t m;
    m.cont   = c[CTRL_CONT];
    m.one    = c[CTRL_ONE] & ~c[CTRL_CONT];
    m.trig_r = c[CTRL_TRIG_R];
    m.trig_f = c[CTRL_TRIG_F];
    return m;
  endfunction

  function automatic logic in_first(input logic [31:0] cnt, input logic [31:0] len);
    return cnt < len;
  endfunction

  // true on the last cycle of a period; a zero period ends every cycle
  function automatic logic period_end(input logic [31:0] cnt, input logic [31:0] per);
    return (cnt + 32'd1) >= per;
  endfunction

  function automatic logic last_rep(input logic [31:0] done_cnt, input logic [31:0] rep);
    return (done_cnt + 32'd1) >= rep;
  endfunction

endpackage

// File: rtl/shpwm_sync2.sv
module shpwm_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= 1'b0;
      q    <= 1'b0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/shpwm_chan.sv
module shpwm_chan
  import shpwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_ctrl,
  input  logic                 wr_rep,
  input  logic                 wr_per,
  input  logic                 wr_fp,
  input  logic                 wr_stat,
  input  logic [31:0]          wdata,
  input  logic                 evt_s,
  output logic [CTRL_BITS-1:0] ctrl_rd,
  output logic [CW-1:0]        rep_rd,
  output logic [CW-1:0]        per_rd,
  output logic [CW-1:0]        fp_rd,
  output logic                 done_o,
  output logic                 pwm_o,
  output logic                 irq_o
);
  localparam logic [CTRL_BITS-1:0] CTRL_KEEP =
    ~((CTRL_BITS'(1) << CTRL_SRST) | (CTRL_BITS'(1) << CTRL_UPD));

  logic [CTRL_BITS-1:0] ctrl_q;
  logic [CW-1:0]        rep_sh, per_sh, fp_sh;
  logic [CW-1:0]        rep_a, per_a, fp_a;
  mode_t                mode_a, mode_sh;
  logic                 upd_pend;
  ch_state_e            state;
  logic [CW-1:0]        cnt, repc;
  logic                 done_q;
  logic                 evt_d;

  // named internal events
  logic srst_ev, upd_req, clr_ev, running, wrap_ev, apply_ev;
  logic rise_ev, fall_ev, trig_ev, trig_sel, launch_ev, last_ev, done_set, rep_zero;

  assign mode_sh   = decode_mode(ctrl_q);
  assign srst_ev   = wr_ctrl & wdata[CTRL_SRST];
  assign upd_req   = wr_ctrl & wdata[CTRL_UPD] & ~wdata[CTRL_SRST];
  assign clr_ev    = wr_stat & wdata[0];
  assign running   = (state == CH_RUN);
  assign wrap_ev   = running & period_end(32'(cnt), 32'(per_a));
  assign apply_ev  = upd_pend & (~running | wrap_ev);
  assign rise_ev   = evt_s & ~evt_d;
  assign fall_ev   = ~evt_s & evt_d;
  assign trig_ev   = ctrl_q[CTRL_RUN] & (state == CH_WAIT) &
                     ((mode_a.trig_r & rise_ev) | (mode_a.trig_f & fall_ev));
  assign trig_sel  = mode_a.trig_r | mode_a.trig_f;
  assign rep_zero  = (rep_a == '0);
  assign launch_ev = ctrl_q[CTRL_RUN] & (state == CH_IDLE) & ~upd_pend &
                     (mode_a.cont | mode_a.one);
  assign last_ev   = ctrl_q[CTRL_RUN] & wrap_ev & mode_a.one &
                     last_rep(32'(repc), 32'(rep_a));
  assign done_set  = (launch_ev & ~mode_a.cont & ~trig_sel & rep_zero) |
                     (trig_ev & rep_zero) | last_ev;

  // control and shadow registers (software side)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rep_sh <= '0;
      per_sh <= '0;
      fp_sh  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata[CTRL_BITS-1:0] & CTRL_KEEP;
      if (wr_rep)  rep_sh <= wdata[CW-1:0];
      if (wr_per)  per_sh <= wdata[CW-1:0];
      if (wr_fp)   fp_sh  <= wdata[CW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_d <= 1'b0;
    else        evt_d <= evt_s;
  end

  // active registers, sequencer and status
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rep_a <= '0; per_a <= '0; fp_a <= '0; mode_a <= '0;
      upd_pend <= 1'b0; state <= CH_IDLE; cnt <= '0; repc <= '0; done_q <= 1'b0;
    end else if (srst_ev) begin
      rep_a <= '0; per_a <= '0; fp_a <= '0; mode_a <= '0;
      upd_pend <= 1'b0; state <= CH_IDLE; cnt <= '0; repc <= '0; done_q <= 1'b0;
    end else begin
      upd_pend <= upd_req | (upd_pend & ~apply_ev);
      if (apply_ev) begin
        rep_a  <= rep_sh;
        per_a  <= per_sh;
        fp_a   <= fp_sh;
        mode_a <= mode_sh;
      end
      if (done_set)    done_q <= 1'b1;
      else if (clr_ev) done_q <= 1'b0;

      if (!ctrl_q[CTRL_RUN]) begin
        state <= CH_IDLE;
        cnt   <= '0;
        repc  <= '0;
      end else begin
        unique case (state)
          CH_IDLE: if (launch_ev) begin
            cnt  <= '0;
            repc <= '0;
            if (mode_a.cont)   state <= CH_RUN;
            else if (trig_sel) state <= CH_WAIT;
            else if (rep_zero) state <= CH_DONE;
            else               state <= CH_RUN;
          end
          CH_WAIT: if (trig_ev) begin
            cnt   <= '0;
            repc  <= '0;
            state <= rep_zero ? CH_DONE : CH_RUN;
          end
          CH_RUN: if (wrap_ev) begin
            cnt <= '0;
            if (last_ev) state <= CH_DONE;
            else if (mode_a.one) repc <= repc + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
          CH_DONE: state <= CH_DONE;
          default: state <= CH_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    if (running)
      pwm_o = in_first(32'(cnt), 32'(fp_a)) ? ctrl_q[CTRL_LVL_FIRST] : ~ctrl_q[CTRL_LVL_FIRST];
    else
      pwm_o = ctrl_q[CTRL_LVL_IDLE];
  end

  assign ctrl_rd = ctrl_q;
  assign rep_rd  = rep_sh;
  assign per_rd  = per_sh;
  assign fp_rd   = fp_sh;
  assign done_o  = done_q;
  assign irq_o   = done_q & ctrl_q[CTRL_IE];

  // R3: active values move only at a boundary or while stopped
  a_r3_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
    running && !wrap_ev && !srst_ev |=> $stable(per_a) && $stable(fp_a) && $stable(rep_a));

  // R3: a pending update is consumed on the next edge while stopped
  a_r3_pending_drains: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pend && !running && !upd_req && !srst_ev |=> !upd_pend);

  // R4: counter stays inside the active period
  a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    running && (per_a != '0) |-> cnt < per_a);

  // R7: the done flag rises only together with entry to the finished state
  a_r7_done_with_state: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> state == CH_DONE);

  // R9: done flag is sticky until cleared or reset
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !clr_ev && !srst_ev |=> done_q);

  // R10: soft reset clears the running state in one edge
  a_r10_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
    srst_ev |=> (cnt == '0) && (per_a == '0) && (fp_a == '0) && !done_q && (state == CH_IDLE));

  // R11: a channel whose active mode is continuous never completes
  a_r11_cont_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    running && mode_a.cont && !srst_ev |=> state != CH_DONE);
endmodule

// File: rtl/shpwm_top.sv
module shpwm_top
  import shpwm_pkg::*;
#(
  parameter int NCH = 6,
  parameter int CW  = 16,
  parameter int AW  = $clog2(NCH) + 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [AW-1:0]  addr,
  input  logic [31:0]    wdata,
  output logic [31:0]    rdata,
  input  logic [NCH-1:0] evt_in,
  output logic [NCH-1:0] pwm_out,
  output logic           irq
);
  localparam int SEL_W = AW - 5;

  logic [SEL_W-1:0] ch_idx;
  logic [4:0]       ofs;
  logic [NCH-1:0]   chan_irq, chan_done;

  logic [CTRL_BITS-1:0] ctrl_rd [NCH];
  logic [CW-1:0]        rep_rd  [NCH];
  logic [CW-1:0]        per_rd  [NCH];
  logic [CW-1:0]        fp_rd   [NCH];

  assign ch_idx = addr[AW-1:5];
  assign ofs    = addr[4:0];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel, evt_s;
    assign sel = (ch_idx == SEL_W'(c));

    shpwm_sync2 u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (evt_in[c]),
      .q     (evt_s)
    );

    shpwm_chan #(.CW(CW)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ctrl (wr_en & sel & (ofs == OFS_CTRL)),
      .wr_rep  (wr_en & sel & (ofs == OFS_REP)),
      .wr_per  (wr_en & sel & (ofs == OFS_PER)),
      .wr_fp   (wr_en & sel & (ofs == OFS_FP)),
      .wr_stat (wr_en & sel & (ofs == OFS_STAT)),
      .wdata   (wdata),
      .evt_s   (evt_s),
      .ctrl_rd (ctrl_rd[c]),
      .rep_rd  (rep_rd[c]),
      .per_rd  (per_rd[c]),
      .fp_rd   (fp_rd[c]),
      .done_o  (chan_done[c]),
      .pwm_o   (pwm_out[c]),
      .irq_o   (chan_irq[c])
    );
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      for (int c = 0; c < NCH; c++) begin
        if (ch_idx == SEL_W'(c)) begin
          unique case (ofs)
            OFS_CTRL: rdata = 32'(ctrl_rd[c]);
            OFS_REP:  rdata = 32'(rep_rd[c]);
            OFS_PER:  rdata = 32'(per_rd[c]);
            OFS_FP:   rdata = 32'(fp_rd[c]);
            OFS_STAT: rdata = 32'(chan_done[c]);
            default:  rdata = '0;
          endcase
        end
      end
    end
  end

  assign irq = |chan_irq;

  // R9: the interrupt never rises without a finished channel
  a_r9_irq_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (chan_done != '0));

  // R1: a read strobe never coincides with a write
  a_r1_single_access: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_en));
endmodule

// File: tb/sim_shpwm_top.sv
module sim_shpwm_top;
  localparam int CLK_PERIOD = 10;
  localparam int C_RUN = 1, C_SRST = 2, C_UPD = 4, C_IE = 8, C_ONE = 16, C_CONT = 32;
  localparam int C_TR = 64, C_TF = 128, C_LF = 256, C_LI = 512;
  localparam int O_CTRL = 0, O_REP = 4, O_PER = 8, O_FP = 12, O_STAT = 16;
  localparam int NV = 5;
  // channel, period, first-phase length, first-phase level
  localparam int VEC [NV][4] = '{'{0, 4, 1, 1}, '{1, 5, 0, 1}, '{2, 5, 5, 0},
                                 '{3, 3, 7, 1}, '{4, 8, 3, 0}};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [5:0]  evt_in = '0;
  logic [5:0]  pwm_out;
  logic        irq;

  int checks = 0, failures = 0;

  shpwm_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .evt_in(evt_in), .pwm_out(pwm_out), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = 8'(a); wdata = 32'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    rd_en = 1'b1; addr = 8'(a);
    #1 d = int'(rdata);
    rd_en = 1'b0;
  endtask

  task automatic count_high(input int ch, input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      h += int'(pwm_out[ch]);
      @(negedge clk);
    end
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int d, h, base, per, fp, lvl, bad;
    idle_cycles(3);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk(pwm_out == 6'b0, "R6 reset outputs at idle 0", int'(pwm_out), 0);
    chk(irq == 1'b0, "R9 reset irq", int'(irq), 0);
    rd(O_CTRL, d);
    chk(d == 0, "R2 reset control", d, 0);

    // register map
    wr(5*32 + O_PER, 32'h1234);
    wr(5*32 + O_FP, 32'h42);
    rd(5*32 + O_PER, d);
    chk(d == 32'h1234, "R1 period readback ch5", d, 32'h1234);
    rd(5*32 + O_FP, d);
    chk(d == 32'h42, "R1 first-phase readback ch5", d, 32'h42);
    rd(6*32 + O_PER, d);
    chk(d == 0, "R1 unmapped window reads 0", d, 0);
    @(negedge clk);
    chk(rdata == 0, "R1 rdata idle without strobe", int'(rdata), 0);
    wr(5*32 + O_CTRL, 32'h3F9);
    rd(5*32 + O_CTRL, d);
    chk(d == 32'h3F9, "R2 control readback", d, 32'h3F9);
    wr(5*32 + O_CTRL, C_SRST | C_UPD | C_LI);
    rd(5*32 + O_CTRL, d);
    chk(d == C_LI, "R2 strobe bits read 0", d, C_LI);

    // table-driven waveform vectors
    for (int v = 0; v < NV; v++) begin
      base = VEC[v][0] * 32; per = VEC[v][1]; fp = VEC[v][2]; lvl = VEC[v][3];
      wr(base + O_CTRL, 0);
      wr(base + O_PER, per);
      wr(base + O_FP, fp);
      wr(base + O_CTRL, C_RUN | C_CONT | C_UPD | (lvl != 0 ? C_LF : 0));
      idle_cycles(2);
      bad = 0;
      for (int k = 0; k < 2*per; k++) begin
        if (int'(pwm_out[VEC[v][0]]) != (((k % per) < fp) ? lvl : 1 - lvl)) bad++;
        @(negedge clk);
      end
      chk(bad == 0, "R4 waveform vector mismatches", bad, 0);
    end

    // shadow behaviour on ch0
    wr(O_CTRL, 0);
    wr(O_PER, 4);
    wr(O_FP, 2);
    wr(O_CTRL, C_RUN | C_CONT | C_UPD | C_LF);
    idle_cycles(2);
    wr(O_PER, 8);
    count_high(0, 8, h);
    chk(h == 4, "R3 period write held until update", h, 4);
    wr(O_CTRL, C_RUN | C_CONT | C_UPD | C_LF);
    idle_cycles(10);
    count_high(0, 16, h);
    chk(h == 4, "R3 new period after update", h, 4);

    // stop, idle level, restart
    wr(O_CTRL, C_CONT | C_LF | C_LI);
    @(negedge clk);
    chk(pwm_out[0] == 1'b1, "R5 stop gives idle level", int'(pwm_out[0]), 1);
    wr(O_CTRL, C_CONT | C_LF);
    chk(pwm_out[0] == 1'b0, "R6 idle level follows bit", int'(pwm_out[0]), 0);
    wr(O_CTRL, C_RUN | C_CONT | C_LF);
    @(negedge clk);
    chk(pwm_out[0] == 1'b1, "R5 restart at first phase", int'(pwm_out[0]), 1);
    idle_cycles(8);
    count_high(0, 16, h);
    chk(h == 4, "R5 values kept across stop", h, 4);

    // one-shot on ch1
    wr(32 + O_CTRL, 0);
    wr(32 + O_PER, 3);
    wr(32 + O_FP, 1);
    wr(32 + O_REP, 2);
    wr(32 + O_CTRL, C_RUN | C_ONE | C_UPD | C_IE | C_LF);
    count_high(1, 14, h);
    chk(h == 2, "R7 one-shot period count", h, 2);
    rd(32 + O_STAT, d);
    chk(d == 1, "R7 done flag set", d, 1);
    chk(irq == 1'b1, "R9 irq with enable", int'(irq), 1);
    wr(32 + O_STAT, 1);
    chk(irq == 1'b0, "R9 irq after clear", int'(irq), 0);
    rd(32 + O_STAT, d);
    chk(d == 0, "R9 status cleared", d, 0);
    wr(32 + O_CTRL, C_ONE | C_LF);
    wr(32 + O_REP, 0);
    wr(32 + O_CTRL, C_RUN | C_ONE | C_UPD | C_LF);
    count_high(1, 6, h);
    chk(h == 0, "R7 zero repeat emits nothing", h, 0);
    rd(32 + O_STAT, d);
    chk(d == 1, "R7 zero repeat sets done", d, 1);
    chk(irq == 1'b0, "R9 no irq when disabled", int'(irq), 0);
    wr(32 + O_CTRL, C_SRST);
    rd(32 + O_STAT, d);
    chk(d == 0, "R10 soft reset clears status", d, 0);

    // rising trigger on ch2
    wr(64 + O_CTRL, 0);
    wr(64 + O_PER, 2);
    wr(64 + O_FP, 1);
    wr(64 + O_REP, 1);
    wr(64 + O_CTRL, C_RUN | C_ONE | C_TR | C_UPD | C_LF);
    count_high(2, 8, h);
    chk(h == 0, "R8 waits for event", h, 0);
    evt_in[2] = 1'b1;
    count_high(2, 10, h);
    chk(h == 1, "R8 runs after rising event", h, 1);
    rd(64 + O_STAT, d);
    chk(d == 1, "R8 done after triggered run", d, 1);

    // falling trigger on ch4
    wr(128 + O_CTRL, 0);
    wr(128 + O_PER, 2);
    wr(128 + O_FP, 1);
    wr(128 + O_REP, 1);
    wr(128 + O_CTRL, C_RUN | C_ONE | C_TF | C_UPD | C_LF);
    idle_cycles(4);
    evt_in[4] = 1'b1;
    count_high(4, 8, h);
    chk(h == 0, "R8 rising edge ignored on falling trigger", h, 0);
    evt_in[4] = 1'b0;
    count_high(4, 10, h);
    chk(h == 1, "R8 runs after falling event", h, 1);

    // both mode bits: continuous wins (ch3)
    wr(96 + O_CTRL, 0);
    wr(96 + O_PER, 4);
    wr(96 + O_FP, 1);
    wr(96 + O_REP, 1);
    wr(96 + O_CTRL, C_RUN | C_ONE | C_CONT | C_UPD | C_LF);
    idle_cycles(4);
    count_high(3, 16, h);
    chk(h == 4, "R11 keeps running as continuous", h, 4);
    rd(96 + O_STAT, d);
    chk(d == 0, "R11 no done flag", d, 0);

    // soft reset on running ch0
    wr(O_CTRL, C_SRST | C_LI);
    chk(pwm_out[0] == 1'b1, "R10 idle level on reset write", int'(pwm_out[0]), 1);
    rd(O_PER, d);
    chk(d == 8, "R10 shadow kept", d, 8);
    wr(O_CTRL, C_RUN | C_CONT | C_LF);
    count_high(0, 10, h);
    chk(h == 0, "R10 active values cleared", h, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule